// File: doc/BRIEF.md
# Switch Port Control-Cell Handler

This block lives in the receive side of a switch port. Every cycle it may take one cell, given as its VPI, its VCI and the first eight payload bytes. A cell that carries the reserved control channel, and arrives while the port accepts control traffic, is decoded as a command. Any other cell is an ordinary data cell. Each data cell is passed on, and the block counts it on the link and on its virtual channel.

A command names an operation and a target port. When the target is some other port, the cell is sent onward toward that port and nothing happens locally. When the target is this port, the block acts on its own state. It can read or write one entry of the 32-entry VC routing table, read a cell counter, or load the option register. It then returns a response carrying a status code, the result word and a timestamp. The timestamp is the value of a free-running cycle count at the moment the command was taken, so a host that reads the same counter twice can work out the load between the two reads.

Top module: `ctl_cell_handler`

## Requirements
- R1: A cell is a command only when `ctlEnable` is 1, its VPI is 0 and its VCI is 31. Every other valid cell is ordinary: `passValid` pulses one cycle later, and no response or onward forward is made.
- R2: A command whose payload byte 1 differs from `portId` is not executed. One cycle later it raises `fwdValid`, with `fwdPort` equal to byte 1, and no response.
- R3: Opcode 2 in payload byte 0 writes the table entry selected by byte2[4:0]. The entry is taken from the word W in bytes 3..6 (byte 3 least significant): W[15:0] is the outgoing VCI, W[19:16] the output port and W[20] the valid bit. The response has status 0 and echoes the entry in `rspData[20:0]`.
- R4: Opcode 1 reads the selected entry back in the same layout, with the upper `rspData` bits zero. After reset every entry is zero.
- R5: Opcode 3 reads a counter. When byte2[7] is 1 it reads the link counter, which counts all ordinary cells. When byte2[7] is 0 it reads the per-VC counter at byte2[4:0]. An ordinary cell is counted on the per-VC counter whose index is its VCI modulo 32.
- R6: Opcode 4 loads byte 3 into `optReg`. The new value is visible one cycle later, with a response of status 0.
- R7: `rspStamp` is the count of a 32-bit cycle counter, cleared by reset, taken in the cycle the command was accepted. Two commands accepted N cycles apart carry stamps that differ by N.
- R8: Any opcode other than 1 to 4 gives a response with status 2 and changes no table entry, counter or `optReg`.
- R9: All results appear exactly one cycle after the cell. At most one of `passValid`, `fwdValid` and `rspValid` is high, and all three are low one cycle after a cycle with no cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlEnable | input | 1 | Port accepts control commands |
| portId | input | 4 | Number of this port |
| cellValid | input | 1 | A cell is presented this cycle |
| cellVpi | input | 8 | VPI of the cell |
| cellVci | input | 16 | VCI of the cell |
| cellPayload | input | 64 | Payload bytes 0..7, byte k in bits 8k+7:8k |
| passValid | output | 1 | Ordinary cell passed on |
| fwdValid | output | 1 | Command forwarded to another port |
| fwdPort | output | 8 | Port the command is forwarded to |
| rspValid | output | 1 | Response produced |
| rspStatus | output | 2 | 0 ok, 2 unknown opcode |
| rspData | output | 32 | Result word |
| rspStamp | output | 32 | Cycle count when the command was taken |
| optReg | output | 8 | Option register |

## Verification
All 32 table entries are written with distinct values derived arithmetically and then read back, so a slip in the index or the field order shows up as a wrong word. Data cells are sent in counts that differ per channel, some on VCIs above 31, together with near-miss control headers and a control cell on a disabled port. Reading every per-VC counter and the link counter then separates a wrong index fold and a missed near-miss from a wrong count. Forward sweeps over all other target numbers, together with sweeps over bad opcodes and option values, check that no local state moves when it must not. Reads taken at several spacings check the stamp arithmetic.

// File: rtl/cch_pkg.sv
package cch_pkg;
  localparam logic [7:0] OP_TBL_RD = 8'd1;
  localparam logic [7:0] OP_TBL_WR = 8'd2;
  localparam logic [7:0] OP_CNT_RD = 8'd3;
  localparam logic [7:0] OP_OPT_WR = 8'd4;

  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_BADOP = 2'd2;

  typedef struct packed {
    logic passCell;
    logic fwdCell;
    logic tblRd;
    logic tblWr;
    logic cntRd;
    logic optWr;
    logic badOp;
  } cchStrobe_t;
endpackage

// File: rtl/cch_ctl.sv
module cch_ctl
  import cch_pkg::*;
#(
  parameter int VPI_W  = 8,
  parameter int VCI_W  = 16,
  parameter int PORT_W = 4,
  parameter logic [VPI_W-1:0] CTL_VPI = '0,
  parameter logic [VCI_W-1:0] CTL_VCI = VCI_W'(31)
) (
  input  logic              cellValid,
  input  logic [VPI_W-1:0]  cellVpi,
  input  logic [VCI_W-1:0]  cellVci,
  input  logic              ctlEnable,
  input  logic [PORT_W-1:0] portId,
  input  logic [7:0]        opCode,
  input  logic [7:0]        targetPort,
  output cchStrobe_t        strobe
);
  logic isCmd;
  logic isLocal;

  always_comb begin
    isCmd   = cellValid && ctlEnable && (cellVpi == CTL_VPI) && (cellVci == CTL_VCI);
    isLocal = (targetPort == 8'(portId));
    strobe          = '0;
    strobe.passCell = cellValid && !isCmd;
    strobe.fwdCell  = isCmd && !isLocal;
    if (isCmd && isLocal) begin
      case (opCode)
        OP_TBL_RD: strobe.tblRd = 1'b1;
        OP_TBL_WR: strobe.tblWr = 1'b1;
        OP_CNT_RD: strobe.cntRd = 1'b1;
        OP_OPT_WR: strobe.optWr = 1'b1;
        default:   strobe.badOp = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cch_dp.sv
module cch_dp
  import cch_pkg::*;
#(
  parameter int NUM_VC = 32,
  parameter int CNT_W  = 32,
  parameter int TS_W   = 32,
  parameter int VCI_W  = 16,
  parameter int PORT_W = 4,
  parameter int OPT_W  = 8,
  parameter int RSP_W  = 32,
  localparam int IDX_W   = $clog2(NUM_VC),
  localparam int ENTRY_W = 1 + PORT_W + VCI_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  cchStrobe_t         strobe,
  input  logic [IDX_W-1:0]   idx,
  input  logic               cntSel,
  input  logic [IDX_W-1:0]   dataIdx,
  input  logic [ENTRY_W-1:0] entryIn,
  input  logic [OPT_W-1:0]   optIn,
  input  logic [7:0]         fwdPortIn,
  output logic               passValid,
  output logic               fwdValid,
  output logic [7:0]         fwdPort,
  output logic               rspValid,
  output logic [1:0]         rspStatus,
  output logic [RSP_W-1:0]   rspData,
  output logic [TS_W-1:0]    rspStamp,
  output logic [OPT_W-1:0]   optReg
);
  logic [NUM_VC-1:0][ENTRY_W-1:0] tblFlat;
  logic [NUM_VC-1:0][CNT_W-1:0]   cntFlat;
  logic [CNT_W-1:0] linkCnt;
  logic [TS_W-1:0]  timeNow;
  logic [RSP_W-1:0] rdData;
  logic [1:0]       stNext;
  logic             anyRsp;

  for (genvar i = 0; i < NUM_VC; i++) begin : g_vc
    logic [ENTRY_W-1:0] entry;
    logic [CNT_W-1:0]   count;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entry <= '0;
        count <= '0;
      end else begin
        if (strobe.tblWr && idx == IDX_W'(i)) entry <= entryIn;
        if (strobe.passCell && dataIdx == IDX_W'(i)) count <= count + 1'b1;
      end
    end
    assign tblFlat[i] = entry;
    assign cntFlat[i] = count;
  end

  always_comb begin
    rdData = '0;
    stNext = ST_OK;
    anyRsp = strobe.tblRd | strobe.tblWr | strobe.cntRd | strobe.optWr | strobe.badOp;
    if (strobe.tblRd)      rdData = RSP_W'(tblFlat[idx]);
    else if (strobe.tblWr) rdData = RSP_W'(entryIn);
    else if (strobe.cntRd) rdData = cntSel ? RSP_W'(linkCnt) : RSP_W'(cntFlat[idx]);
    else if (strobe.optWr) rdData = RSP_W'(optIn);
    if (strobe.badOp) stNext = ST_BADOP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passValid <= 1'b0;
      fwdValid  <= 1'b0;
      fwdPort   <= '0;
      rspValid  <= 1'b0;
      rspStatus <= ST_OK;
      rspData   <= '0;
      rspStamp  <= '0;
      timeNow   <= '0;
      linkCnt   <= '0;
      optReg    <= '0;
    end else begin
      passValid <= strobe.passCell;
      fwdValid  <= strobe.fwdCell;
      fwdPort   <= fwdPortIn;
      rspValid  <= anyRsp;
      rspStatus <= stNext;
      rspData   <= rdData;
      rspStamp  <= timeNow;
      timeNow   <= timeNow + 1'b1;
      if (strobe.passCell) linkCnt <= linkCnt + 1'b1;
      if (strobe.optWr)    optReg  <= optIn;
    end
  end
endmodule

// File: rtl/ctl_cell_handler.sv
module ctl_cell_handler
  import cch_pkg::*;
#(
  parameter int NUM_VC = 32,
  parameter int CNT_W  = 32,
  parameter int TS_W   = 32,
  parameter int VPI_W  = 8,
  parameter int VCI_W  = 16,
  parameter int PORT_W = 4,
  parameter int OPT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctlEnable,
  input  logic [PORT_W-1:0] portId,
  input  logic              cellValid,
  input  logic [VPI_W-1:0]  cellVpi,
  input  logic [VCI_W-1:0]  cellVci,
  input  logic [63:0]       cellPayload,
  output logic              passValid,
  output logic              fwdValid,
  output logic [7:0]        fwdPort,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic [31:0]       rspData,
  output logic [TS_W-1:0]   rspStamp,
  output logic [OPT_W-1:0]  optReg
);
  localparam int IDX_W   = $clog2(NUM_VC);
  localparam int ENTRY_W = 1 + PORT_W + VCI_W;

  cchStrobe_t strobe;
  logic [7:0]  opByte;
  logic [7:0]  tgtByte;
  logic [7:0]  idxByte;
  logic [31:0] argWord;
  logic        unusedBits;

  assign opByte     = cellPayload[7:0];
  assign tgtByte    = cellPayload[15:8];
  assign idxByte    = cellPayload[23:16];
  assign argWord    = cellPayload[55:24];
  assign unusedBits = ^{cellPayload[63:56], idxByte[6:IDX_W], argWord[31:ENTRY_W],
                        cellVci[VCI_W-1:IDX_W]};

  cch_ctl #(.VPI_W(VPI_W), .VCI_W(VCI_W), .PORT_W(PORT_W)) u_ctl (
    .cellValid (cellValid),
    .cellVpi   (cellVpi),
    .cellVci   (cellVci),
    .ctlEnable (ctlEnable),
    .portId    (portId),
    .opCode    (opByte),
    .targetPort(tgtByte),
    .strobe    (strobe)
  );

  cch_dp #(.NUM_VC(NUM_VC), .CNT_W(CNT_W), .TS_W(TS_W), .VCI_W(VCI_W),
           .PORT_W(PORT_W), .OPT_W(OPT_W), .RSP_W(32)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .idx      (idxByte[IDX_W-1:0]),
    .cntSel   (idxByte[7]),
    .dataIdx  (cellVci[IDX_W-1:0]),
    .entryIn  (argWord[ENTRY_W-1:0]),
    .optIn    (argWord[OPT_W-1:0]),
    .fwdPortIn(tgtByte),
    .passValid(passValid),
    .fwdValid (fwdValid),
    .fwdPort  (fwdPort),
    .rspValid (rspValid),
    .rspStatus(rspStatus),
    .rspData  (rspData),
    .rspStamp (rspStamp),
    .optReg   (optReg)
  );
endmodule

// File: rtl/ctl_cell_handler_chk.sv
module ctl_cell_handler_chk #(
  parameter int VPI_W  = 8,
  parameter int VCI_W  = 16,
  parameter int PORT_W = 4,
  parameter int OPT_W  = 8,
  parameter int TS_W   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctlEnable,
  input logic [PORT_W-1:0] portId,
  input logic              cellValid,
  input logic [VPI_W-1:0]  cellVpi,
  input logic [VCI_W-1:0]  cellVci,
  input logic [63:0]       cellPayload,
  input logic              passValid,
  input logic              fwdValid,
  input logic [7:0]        fwdPort,
  input logic              rspValid,
  input logic [1:0]        rspStatus,
  input logic [TS_W-1:0]   rspStamp,
  input logic [OPT_W-1:0]  optReg
);
  logic cmdIn;
  logic localIn;
  logic unusedChk;

  assign cmdIn     = cellValid && ctlEnable && cellVpi == '0 && cellVci == VCI_W'(31);
  assign localIn   = cellPayload[15:8] == 8'(portId);
  assign unusedChk = ^{cellPayload[63:32], cellPayload[23:16]};

  a_r1_ordinary: assert property (@(posedge clk) disable iff (!rstN)
    cellValid && !cmdIn |=> passValid && !fwdValid && !rspValid);

  a_r2_forward: assert property (@(posedge clk) disable iff (!rstN)
    cmdIn && !localIn |=> fwdValid && !rspValid && fwdPort == $past(cellPayload[15:8]));

  a_r6_option: assert property (@(posedge clk) disable iff (!rstN)
    cmdIn && localIn && cellPayload[7:0] == 8'd4 |=>
      rspValid && rspStatus == 2'd0 && optReg == $past(cellPayload[31:24]));

  a_r8_badop: assert property (@(posedge clk) disable iff (!rstN)
    cmdIn && localIn && (cellPayload[7:0] == 8'd0 || cellPayload[7:0] > 8'd4) |=>
      rspValid && rspStatus == 2'd2 && $stable(optReg));

  a_r7_stamp_step: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && $past(rspValid) |-> rspStamp == $past(rspStamp) + 1'b1);

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({passValid, fwdValid, rspValid}));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rstN)
    !cellValid |=> !passValid && !fwdValid && !rspValid);
endmodule

bind ctl_cell_handler ctl_cell_handler_chk #(
  .VPI_W(VPI_W), .VCI_W(VCI_W), .PORT_W(PORT_W), .OPT_W(OPT_W), .TS_W(TS_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctlEnable  (ctlEnable),
  .portId     (portId),
  .cellValid  (cellValid),
  .cellVpi    (cellVpi),
  .cellVci    (cellVci),
  .cellPayload(cellPayload),
  .passValid  (passValid),
  .fwdValid   (fwdValid),
  .fwdPort    (fwdPort),
  .rspValid   (rspValid),
  .rspStatus  (rspStatus),
  .rspStamp   (rspStamp),
  .optReg     (optReg)
);

// File: tb/tb_ctl_cell_handler.sv
module tb_ctl_cell_handler;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlEnable = 1'b1;
  logic [3:0]  portId = 4'd5;
  logic        cellValid = 1'b0;
  logic [7:0]  cellVpi = '0;
  logic [15:0] cellVci = '0;
  logic [63:0] cellPayload = '0;
  logic        passValid, fwdValid, rspValid;
  logic [7:0]  fwdPort, optReg;
  logic [1:0]  rspStatus;
  logic [31:0] rspData, rspStamp;

  int checks = 0;
  int errors = 0;
  int expVc [32];
  int expLink = 0;
  logic [7:0]  expOpt = 8'd0;
  logic [31:0] s1, s2;

  always #4 clk = ~clk;

  ctl_cell_handler dut (
    .clk(clk), .rstN(rstN), .ctlEnable(ctlEnable), .portId(portId),
    .cellValid(cellValid), .cellVpi(cellVpi), .cellVci(cellVci),
    .cellPayload(cellPayload), .passValid(passValid), .fwdValid(fwdValid),
    .fwdPort(fwdPort), .rspValid(rspValid), .rspStatus(rspStatus),
    .rspData(rspData), .rspStamp(rspStamp), .optReg(optReg)
  );

  function automatic logic [63:0] mkPl(input logic [7:0] op, input logic [7:0] tgt,
                                       input logic [7:0] idx, input logic [31:0] word);
    return {8'h00, word, idx, tgt, op};
  endfunction

  function automatic logic [31:0] entryOf(input int i);
    logic [20:0] e;
    e = {i[0], 4'(i * 3), 16'(i * 97 + 3)};
    return 32'(e);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendCell(input logic [7:0] vpi, input logic [15:0] vci, input logic [63:0] pl);
    @(negedge clk);
    cellVpi = vpi;
    cellVci = vci;
    cellPayload = pl;
    cellValid = 1'b1;
    @(posedge clk);
    #1;
    cellValid = 1'b0;
  endtask

  task automatic sendCmd(input logic [63:0] pl);
    sendCell(8'd0, 16'd31, pl);
  endtask

  task automatic sendData(input logic [7:0] vpi, input logic [15:0] vci, input logic [63:0] pl);
    sendCell(vpi, vci, pl);
    expVc[vci % 32]++;
    expLink++;
    check("R1 ordinary cell passed", 32'(passValid), 32'd1);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog R9 actual=running expected=done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 32; i++) expVc[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R9 reset valids", 32'({passValid, fwdValid, rspValid}), 32'd0);
    check("R6 reset optReg", 32'(optReg), 32'd0);

    // R4: entry reads zero after reset
    sendCmd(mkPl(8'd1, 8'd5, 8'd0, 32'd0));
    check("R4 reset entry", rspData, 32'd0);

    // R3: write every entry
    for (int i = 0; i < 32; i++) begin
      sendCmd(mkPl(8'd2, 8'd5, 8'(i), entryOf(i) | 32'hFFE0_0000));
      check("R3 write status", 32'({rspValid, rspStatus}), 32'h4);
      check("R3 write echo", rspData, entryOf(i));
    end
    // R4: read every entry back
    for (int i = 0; i < 32; i++) begin
      sendCmd(mkPl(8'd1, 8'd5, 8'(i), 32'd0));
      check("R4 read entry", rspData, entryOf(i));
    end

    // R1/R5: data cells with per-channel counts, some folded from VCI >= 32
    for (int v = 0; v < 32; v++)
      for (int k = 0; k <= v % 4; k++)
        sendData(8'd1, 16'(v), 64'(v));
    for (int v = 0; v < 8; v++) sendData(8'd3, 16'(v + 32), 64'd0);
    sendData(8'd2, 16'd31, mkPl(8'd4, 8'd5, 8'd0, 32'h77));
    sendData(8'd0, 16'd30, mkPl(8'd4, 8'd5, 8'd0, 32'h66));
    ctlEnable = 1'b0;
    sendData(8'd0, 16'd31, mkPl(8'd4, 8'd5, 8'd0, 32'hAA));
    check("R1 disabled cmd no response", 32'({rspValid, fwdValid}), 32'd0);
    check("R1 disabled cmd optReg", 32'(optReg), 32'(expOpt));
    ctlEnable = 1'b1;

    for (int v = 0; v < 32; v++) begin
      sendCmd(mkPl(8'd3, 8'd5, 8'(v), 32'd0));
      check("R5 per-VC counter", rspData, 32'(expVc[v]));
    end
    sendCmd(mkPl(8'd3, 8'd5, 8'h80, 32'd0));
    check("R5 link counter", rspData, 32'(expLink));

    // R2: commands for other ports are forwarded, not executed
    for (int t = 0; t < 16; t++) begin
      if (t != 5) begin
        sendCmd(mkPl(8'd4, 8'(t), 8'd0, 32'(t + 8'h40)));
        check("R2 forward flag", 32'({fwdValid, rspValid, passValid}), 32'h4);
        check("R2 forward port", 32'(fwdPort), 32'(t));
        check("R2 optReg untouched", 32'(optReg), 32'(expOpt));
      end
    end
    sendCmd(mkPl(8'd2, 8'd200, 8'd3, 32'h1F_FFFF));
    check("R2 forward port 200", 32'(fwdPort), 32'd200);
    sendCmd(mkPl(8'd1, 8'd5, 8'd3, 32'd0));
    check("R2 entry untouched", rspData, entryOf(3));
    sendCmd(mkPl(8'd3, 8'd5, 8'h80, 32'd0));
    check("R2 link counter unchanged", rspData, 32'(expLink));

    // R6: option sweep
    for (int i = 0; i < 16; i++) begin
      expOpt = 8'(i * 17 + 1);
      sendCmd(mkPl(8'd4, 8'd5, 8'd0, 32'(expOpt)));
      check("R6 optReg", 32'(optReg), 32'(expOpt));
      check("R6 status", 32'({rspValid, rspStatus}), 32'h4);
    end

    // R8: unknown opcodes
    for (int op = 0; op < 24; op++) begin
      if (op == 0 || op > 4) begin
        sendCmd(mkPl(8'(op), 8'd5, 8'd3, 32'h0000_0055));
        check("R8 bad status", 32'({rspValid, rspStatus}), 32'h6);
        check("R8 optReg unchanged", 32'(optReg), 32'(expOpt));
      end
    end
    sendCmd(mkPl(8'hFF, 8'd5, 8'd3, 32'h0000_0055));
    check("R8 bad status 255", 32'(rspStatus), 32'd2);
    sendCmd(mkPl(8'd1, 8'd5, 8'd3, 32'd0));
    check("R8 entry unchanged", rspData, entryOf(3));
    sendCmd(mkPl(8'd3, 8'd5, 8'd3, 32'd0));
    check("R8 counter unchanged", rspData, 32'(expVc[3]));

    // R7: stamp spacing
    for (int gap = 0; gap < 12; gap += 3) begin
      sendCmd(mkPl(8'd3, 8'd5, 8'h80, 32'd0));
      s1 = rspStamp;
      repeat (gap) @(posedge clk);
      sendCmd(mkPl(8'd3, 8'd5, 8'h80, 32'd0));
      s2 = rspStamp;
      check("R7 stamp delta", s2 - s1, 32'(gap + 1));
    end

    // R9: outputs drop one cycle after the last cell
    @(posedge clk);
    #1;
    check("R9 idle outputs", 32'({passValid, fwdValid, rspValid}), 32'd0);

    finishRun();
  end
endmodule